// File: doc/BRIEF.md
# Sectored Disk Channel Adapter

This block connects a byte-serial I/O channel to a disk with one platter and two recording surfaces. Every track holds eight sectors of equal length. The channel hands the adapter one command byte at a time, together with a byte count. For a seek, the channel then sends one more byte, which holds the target cylinder. For a read or a write, the command byte carries the surface (head) bit and the sector to start at. Data then flows one byte per disk byte time, from that sector up to the last sector of the track.

The disk side is modelled in a simple way. A pulse with a sector number marks the start of each sector, and a byte strobe marks each byte time inside it. Once the adapter has locked onto its starting sector, it counts bytes and sectors by itself. The adapter also decides when the transfer is over:

- It signals channel-end when the channel count runs out, or when the track runs out first.
- It signals device-end on the sector boundary set by the read and write ending rules.
- When a write runs short, it pads the rest of the current sector with zero bytes.

A sense command returns a one-byte status. That byte holds a command-reject flag, a wrong-length flag and a seek-error flag.

Top module: `dca_top`

## Requirements
- R1: Command bytes are decoded as follows: 00001011 is a seek, HSSS1010 is a read, HSSS1001 is a write, 00000010 is an initial-load read (head 0, sector 0), 00000011 is a no-op and 00000100 is a sense. A no-op gives chan_end and dev_end together one cycle after it is accepted. Any other byte sets the reject flag and gives chan_end and dev_end together, with no data moved.
- R2: A seek consumes exactly one ch_in_valid byte. With that byte it gives chan_end together with a one-cycle seek_go pulse, and seek_cyl holds the byte. When seek_done arrives, it gives dev_end and cur_cyl takes the new cylinder.
- R3: If the seek byte is above MAX_CYL (202), the seek-error flag is set, chan_end and dev_end come together, no seek_go is produced and cur_cyl keeps its old value.
- R4: A read or a write drives disk_head with bit 7 of the command and begins at the sector held in bits 6:4. It moves one byte per disk_tick from that sector onward and never goes past sector 7. Read bytes are passed to ch_rd_data unchanged.
- R5: A read whose count runs out partway through a sector, or on the last byte of sector 7, ends with dev_end on the last byte time of that same sector. If the track ends first, chan_end and dev_end come together there.
- R6: A read whose count runs out exactly on the last byte of one of sectors 0 to 6 holds back dev_end until the last byte time of the next sector. No further data goes to the channel in the meantime.
- R7: A write sends one channel byte per byte time, and ch_take follows each byte taken. After the count runs out, the rest of that sector is written as zero bytes and dev_end comes on its last byte. A count that runs out exactly on a sector's last byte ends at that boundary, with no padding.
- R8: At the end of a read or a write, the wrong-length flag (status bit 1) is cleared only if the count ran out exactly on the last byte of sector 7. Otherwise it is set.
- R9: A sense returns one byte on ch_rd_valid, together with chan_end and dev_end. Bit 0 of that byte is reject, bit 1 is wrong-length and bit 2 is seek-error. The sense then clears all three flags. Every other command also clears them when it is accepted.
- R10: After reset, busy is 0 and cur_cyl is 0. While busy is high, cmd_valid is ignored. dev_end always comes with busy falling.
- R11: A read or a write gives exactly one chan_end. It comes on the byte time where the count reaches zero, or at the end of the track if the count has not run out by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered (accepted when idle) |
| cmd_byte | input | 8 | Command code |
| cmd_count | input | CNT_W | Channel byte count for the command |
| ch_in_valid | input | 1 | Seek byte present on ch_data_in |
| ch_data_in | input | 8 | Seek byte or write data from the channel |
| ch_take | output | 1 | Write data byte was consumed |
| ch_rd_valid | output | 1 | Byte to channel (read data or sense) |
| ch_rd_data | output | 8 | Byte to channel |
| chan_end | output | 1 | Channel-end pulse |
| dev_end | output | 1 | Device-end pulse |
| busy | output | 1 | Command in progress |
| seek_go | output | 1 | Start actuator pulse |
| seek_cyl | output | 8 | Target cylinder |
| seek_done | input | 1 | Actuator reached target |
| cur_cyl | output | 8 | Current cylinder |
| disk_head | output | 1 | Selected surface |
| disk_sec_pulse | input | 1 | Sector start mark |
| disk_sec_num | input | 3 | Number of the sector starting |
| disk_tick | input | 1 | Disk byte time |
| disk_rd_data | input | 8 | Byte read from disk |
| disk_wr_en | output | 1 | Write byte strobe |
| disk_wr_data | output | 8 | Byte written to disk |

## Verification
The assertions take for granted that:

- disk_tick never occurs in two adjacent cycles and never occurs in the same cycle as a sector pulse.
- seek_done arrives only after seek_go.
- The channel has placed the next write byte on ch_data_in before the next byte time.

The stimulus meets these assumptions as follows:

- The disk model spaces its byte strobes three cycles apart.
- The model issues each sector pulse in a cycle of its own.
- The bench raises seek_done only once it has seen seek_go.
- The bench advances the write data as soon as it sees ch_take.

// File: rtl/dca_pkg.sv
package dca_pkg;
  localparam int SEC_W = 3;
  localparam int NSEC  = 1 << SEC_W;

  typedef enum logic [2:0] {
    OP_SEEK, OP_READ, OP_WRITE, OP_IPL, OP_NOOP, OP_SENSE, OP_BAD
  } dca_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEEK_BYTE, ST_SEEK_WAIT, ST_SYNC, ST_XFER
  } dca_state_e;

  typedef struct packed {
    logic seek_err;
    logic inc_len;
    logic cmd_rej;
  } dca_stat_t;

  function automatic dca_op_e op_of(input logic [7:0] c);
    casez (c)
      8'b00001011: return OP_SEEK;
      8'b00000010: return OP_IPL;
      8'b00000011: return OP_NOOP;
      8'b00000100: return OP_SENSE;
      8'b????1010: return OP_READ;
      8'b????1001: return OP_WRITE;
      default:     return OP_BAD;
    endcase
  endfunction

  function automatic logic [7:0] sense_byte(input dca_stat_t s);
    return {5'b00000, s};
  endfunction

  function automatic logic cyl_ok(input logic [7:0] c, input int unsigned lim);
    return 32'(c) <= lim;
  endfunction

  // read: free at a sector end once the count is already empty, or at track end
  function automatic logic read_ends(input logic last_sec, input logic cnt_zero);
    return last_sec | cnt_zero;
  endfunction

  // write: free at the sector end where the count empties or is already empty
  function automatic logic write_ends(input logic last_sec, input logic cnt_zero,
                                      input logic cnt_one);
    return last_sec | cnt_zero | cnt_one;
  endfunction
endpackage

// File: rtl/dca_cmd_decode.sv
module dca_cmd_decode
  import dca_pkg::*;
(
  input  logic [7:0]       cmd,
  output dca_op_e          op,
  output logic             head,
  output logic [SEC_W-1:0] sec
);
  always_comb begin
    op   = op_of(cmd);
    head = cmd[7];
    sec  = cmd[6:4];
  end
endmodule

// File: rtl/dca_byte_count.sv
module dca_byte_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_one
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (dec)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dca_track_pos.sv
module dca_track_pos
  import dca_pkg::*;
#(
  parameter int SECT_BYTES = 366
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] start,
  input  logic             step,
  output logic             last_byte,
  output logic             last_sec
);
  localparam int IDX_W = (SECT_BYTES > 1) ? $clog2(SECT_BYTES) : 1;

  logic [IDX_W-1:0] idx_q;
  logic [SEC_W-1:0] sec_q;

  assign last_byte = (idx_q == IDX_W'(SECT_BYTES - 1));
  assign last_sec  = (sec_q == SEC_W'(NSEC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      sec_q <= '0;
    end else if (load) begin
      idx_q <= '0;
      sec_q <= start;
    end else if (step) begin
      if (last_byte) begin
        idx_q <= '0;
        sec_q <= sec_q + SEC_W'(1);
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/dca_top.sv
module dca_top
  import dca_pkg::*;
#(
  parameter int SECT_BYTES = 366,
  parameter int CNT_W      = 16,
  parameter int MAX_CYL    = 202
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             ch_in_valid,
  input  logic [7:0]       ch_data_in,
  output logic             ch_take,
  output logic             ch_rd_valid,
  output logic [7:0]       ch_rd_data,
  output logic             chan_end,
  output logic             dev_end,
  output logic             busy,
  output logic             seek_go,
  output logic [7:0]       seek_cyl,
  input  logic             seek_done,
  output logic [7:0]       cur_cyl,
  output logic             disk_head,
  input  logic             disk_sec_pulse,
  input  logic [2:0]       disk_sec_num,
  input  logic             disk_tick,
  input  logic [7:0]       disk_rd_data,
  output logic             disk_wr_en,
  output logic [7:0]       disk_wr_data
);
  dca_state_e       state_q;
  dca_stat_t        stat_q;
  dca_op_e          dec_op;
  logic             dec_head;
  logic [SEC_W-1:0] dec_sec;
  logic [SEC_W-1:0] start_q;
  logic             is_write_q;

  // named internal events
  logic accept, xfer_op, sync_hit, step, moving;
  logic last_byte, last_sec, cnt_zero, cnt_one;
  logic xfer_finish, count_exhaust, track_cut, len_ok;

  dca_cmd_decode u_dec (
    .cmd (cmd_byte),
    .op  (dec_op),
    .head(dec_head),
    .sec (dec_sec)
  );

  assign accept   = (state_q == ST_IDLE) && cmd_valid;
  assign xfer_op  = (dec_op == OP_READ) || (dec_op == OP_WRITE) || (dec_op == OP_IPL);
  assign sync_hit = (state_q == ST_SYNC) && disk_sec_pulse && (disk_sec_num == start_q);
  assign step     = (state_q == ST_XFER) && disk_tick;
  assign moving   = step && !cnt_zero;

  dca_byte_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept && xfer_op),
    .load_val(cmd_count),
    .dec     (moving),
    .is_zero (cnt_zero),
    .is_one  (cnt_one)
  );

  dca_track_pos #(.SECT_BYTES(SECT_BYTES)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sync_hit),
    .start    (start_q),
    .step     (step),
    .last_byte(last_byte),
    .last_sec (last_sec)
  );

  assign xfer_finish   = step && last_byte &&
                         (is_write_q ? write_ends(last_sec, cnt_zero, cnt_one)
                                     : read_ends(last_sec, cnt_zero));
  assign count_exhaust = moving && cnt_one;
  assign track_cut     = xfer_finish && last_sec && !cnt_zero && !cnt_one;
  assign len_ok        = step && last_byte && last_sec && cnt_one;

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      stat_q       <= '0;
      start_q      <= '0;
      is_write_q   <= 1'b0;
      disk_head    <= 1'b0;
      seek_cyl     <= '0;
      cur_cyl      <= '0;
      ch_take      <= 1'b0;
      ch_rd_valid  <= 1'b0;
      ch_rd_data   <= '0;
      chan_end     <= 1'b0;
      dev_end      <= 1'b0;
      seek_go      <= 1'b0;
      disk_wr_en   <= 1'b0;
      disk_wr_data <= '0;
    end else begin
      ch_take     <= 1'b0;
      ch_rd_valid <= 1'b0;
      chan_end    <= 1'b0;
      dev_end     <= 1'b0;
      seek_go     <= 1'b0;
      disk_wr_en  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            stat_q <= '0;
            case (dec_op)
              OP_SEEK: state_q <= ST_SEEK_BYTE;
              OP_READ, OP_WRITE, OP_IPL: begin
                disk_head  <= dec_head;
                start_q    <= dec_sec;
                is_write_q <= (dec_op == OP_WRITE);
                state_q    <= ST_SYNC;
                if (cmd_count == '0) chan_end <= 1'b1;
              end
              OP_NOOP: begin
                chan_end <= 1'b1;
                dev_end  <= 1'b1;
              end
              OP_SENSE: begin
                ch_rd_valid <= 1'b1;
                ch_rd_data  <= sense_byte(stat_q);
                chan_end    <= 1'b1;
                dev_end     <= 1'b1;
              end
              default: begin
                stat_q.cmd_rej <= 1'b1;
                chan_end       <= 1'b1;
                dev_end        <= 1'b1;
              end
            endcase
          end
        end
        ST_SEEK_BYTE: begin
          if (ch_in_valid) begin
            chan_end <= 1'b1;
            if (cyl_ok(ch_data_in, MAX_CYL)) begin
              seek_go  <= 1'b1;
              seek_cyl <= ch_data_in;
              state_q  <= ST_SEEK_WAIT;
            end else begin
              stat_q.seek_err <= 1'b1;
              dev_end         <= 1'b1;
              state_q         <= ST_IDLE;
            end
          end
        end
        ST_SEEK_WAIT: begin
          if (seek_done) begin
            cur_cyl <= seek_cyl;
            dev_end <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_SYNC: begin
          if (sync_hit) state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (step) begin
            if (is_write_q) begin
              disk_wr_en   <= 1'b1;
              disk_wr_data <= cnt_zero ? 8'h00 : ch_data_in;
              ch_take      <= !cnt_zero;
            end else if (!cnt_zero) begin
              ch_rd_valid <= 1'b1;
              ch_rd_data  <= disk_rd_data;
            end
            if (count_exhaust || track_cut) chan_end <= 1'b1;
            if (xfer_finish) begin
              dev_end        <= 1'b1;
              stat_q.inc_len <= !len_ok;
              state_q        <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dca_chk.sv
module dca_chk #(
  parameter int MAX_CYL = 202
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       dev_end,
  input logic       chan_end,
  input logic       seek_go,
  input logic [7:0] seek_cyl,
  input logic [7:0] cur_cyl,
  input logic       ch_take,
  input logic       ch_rd_valid,
  input logic       disk_wr_en,
  input logic [7:0] disk_wr_data,
  input logic       xfer_finish,
  input logic       step
);
  p_seek_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seek_go |-> (32'(seek_cyl) <= MAX_CYL));

  p_seek_pairs_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seek_go |-> chan_end);

  p_cyl_moves_with_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cyl != $past(cur_cyl)) |-> dev_end);

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disk_wr_en && !ch_take) |-> (disk_wr_data == 8'h00));

  p_take_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_take |-> disk_wr_en);

  p_one_direction_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_rd_valid && disk_wr_en));

  p_devend_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_end |-> !busy);

  p_finish_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_finish |=> (dev_end && !busy));

  p_step_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy);
endmodule

bind dca_top dca_chk #(.MAX_CYL(MAX_CYL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .dev_end     (dev_end),
  .chan_end    (chan_end),
  .seek_go     (seek_go),
  .seek_cyl    (seek_cyl),
  .cur_cyl     (cur_cyl),
  .ch_take     (ch_take),
  .ch_rd_valid (ch_rd_valid),
  .disk_wr_en  (disk_wr_en),
  .disk_wr_data(disk_wr_data),
  .xfer_finish (xfer_finish),
  .step        (step)
);

// File: tb/dca_top_test.sv
module dca_top_test;
  localparam int SB    = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic ch_in_valid = 1'b0;
  logic [7:0] ch_data_in;
  logic ch_take, ch_rd_valid, chan_end, dev_end, busy, seek_go, disk_head;
  logic [7:0] ch_rd_data, seek_cyl, cur_cyl, disk_wr_data;
  logic seek_done = 1'b0;
  logic disk_sec_pulse = 1'b0;
  logic [2:0] disk_sec_num = '0;
  logic disk_tick = 1'b0;
  logic [7:0] disk_rd_data = '0;
  logic disk_wr_en;

  logic seek_drv = 1'b0;
  logic [7:0] seek_val = '0;
  int take_cnt = 0;
  int wr_base = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [20:0] exp_q[$];
  string tag_q[$];

  assign ch_data_in = seek_drv ? seek_val : (8'hA0 + 8'(take_cnt - wr_base));

  always #10 clk = ~clk;

  dca_top #(.SECT_BYTES(SB), .CNT_W(CNT_W), .MAX_CYL(202)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_count(cmd_count), .ch_in_valid(ch_in_valid), .ch_data_in(ch_data_in),
    .ch_take(ch_take), .ch_rd_valid(ch_rd_valid), .ch_rd_data(ch_rd_data),
    .chan_end(chan_end), .dev_end(dev_end), .busy(busy), .seek_go(seek_go),
    .seek_cyl(seek_cyl), .seek_done(seek_done), .cur_cyl(cur_cyl),
    .disk_head(disk_head), .disk_sec_pulse(disk_sec_pulse),
    .disk_sec_num(disk_sec_num), .disk_tick(disk_tick),
    .disk_rd_data(disk_rd_data), .disk_wr_en(disk_wr_en),
    .disk_wr_data(disk_wr_data)
  );

  // rotating disk: pulse, then SB byte strobes spaced three cycles apart
  initial begin
    forever begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk); disk_sec_pulse = 1'b1; disk_sec_num = 3'(s);
        @(negedge clk); disk_sec_pulse = 1'b0;
        for (int b = 0; b < SB; b++) begin
          @(negedge clk); disk_tick = 1'b1; disk_rd_data = {disk_head, 3'(s), 4'(b)};
          @(negedge clk); disk_tick = 1'b0;
          @(negedge clk);
        end
      end
    end
  end

  function automatic logic [20:0] pack(input bit sg, input bit rv, input logic [7:0] rd,
                                       input bit we, input logic [7:0] wd,
                                       input bit ce, input bit de);
    return {sg, rv, rd, we, wd, ce, de};
  endfunction

  task automatic push(input logic [20:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic [20:0] w;
      w = {seek_go, ch_rd_valid, ch_rd_data & {8{ch_rd_valid}}, disk_wr_en,
           disk_wr_data & {8{disk_wr_en}}, chan_end, dev_end};
      if (ch_take) take_cnt++;
      if (w != '0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected event", int'(w), 0);
        end else begin
          logic [20:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(w == e, t, int'(w), int'(e));
        end
      end
    end
  end

  task automatic issue(input logic [7:0] c, input int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = c; cmd_count = CNT_W'(n);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sense(input logic [7:0] st, input string tag);
    push(pack(0, 1, st, 0, 8'h00, 1, 1), tag);
    issue(8'h04, 0);
    wait_idle();
  endtask

  // expected events of a read or write built from the ending rules
  task automatic exp_xfer(input bit wr, input bit h, input int s, input int c,
                          input string tag, output bit ilen);
    int rem;
    int n;
    bit fin;
    logic [20:0] w;
    rem = c; n = 0; fin = 0;
    for (int sec = s; sec < 8 && !fin; sec++) begin
      for (int b = 0; b < SB && !fin; b++) begin
        w = '0;
        if (wr) begin
          w[10] = 1'b1;
          if (rem > 0) w[9:2] = 8'hA0 + 8'(n);
        end else if (rem > 0) begin
          w[19] = 1'b1;
          w[18:11] = {h, 3'(sec), 4'(b)};
        end
        if (rem == 1) w[1] = 1'b1;
        if (b == SB - 1) begin
          if (sec == 7) begin
            fin = 1;
            if (rem > 1) w[1] = 1'b1;
          end else if (wr ? (rem <= 1) : (rem == 0)) begin
            fin = 1;
          end
          if (fin) w[0] = 1'b1;
        end
        if (rem > 0) begin rem--; n++; end
        if (w != '0) push(w, tag);
      end
    end
    ilen = (c != (8 - s) * SB);
  endtask

  task automatic run_xfer(input bit wr, input bit h, input int s, input int c,
                          input string tag);
    bit ilen;
    wr_base = take_cnt;
    exp_xfer(wr, h, s, c, tag, ilen);
    issue({h, 3'(s), wr ? 4'b1001 : 4'b1010}, c);
    check(disk_head == h, "R4 head select", int'(disk_head), int'(h));
    wait_idle();
    sense({5'b0, 1'b0, ilen, 1'b0}, "R8 length flag");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && cur_cyl == 8'h00 && chan_end == 1'b0, "R10 reset state",
          int'({busy, cur_cyl}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 no-op and reject
    push(pack(0, 0, 0, 0, 0, 1, 1), "R1 noop ends");
    issue(8'h03, 0); wait_idle();
    push(pack(0, 0, 0, 0, 0, 1, 1), "R1 reject ends");
    issue(8'hFF, 5); wait_idle();
    sense(8'h01, "R9 reject bit");
    sense(8'h00, "R9 flags cleared");

    // R2 good seek
    push(pack(1, 0, 0, 0, 0, 1, 0), "R2 seek byte");
    issue(8'h0B, 1);
    @(negedge clk); seek_drv = 1'b1; seek_val = 8'd57; ch_in_valid = 1'b1;
    @(negedge clk); ch_in_valid = 1'b0; seek_drv = 1'b0;
    check(seek_cyl == 8'd57, "R2 seek target", int'(seek_cyl), 57);
    repeat (4) @(negedge clk);
    push(pack(0, 0, 0, 0, 0, 0, 1), "R2 seek complete");
    seek_done = 1'b1; @(negedge clk); seek_done = 1'b0;
    wait_idle();
    check(cur_cyl == 8'd57, "R2 cylinder", int'(cur_cyl), 57);

    // R3 out-of-range seek
    push(pack(0, 0, 0, 0, 0, 1, 1), "R3 bad seek ends");
    issue(8'h0B, 1);
    @(negedge clk); seek_drv = 1'b1; seek_val = 8'd203; ch_in_valid = 1'b1;
    @(negedge clk); ch_in_valid = 1'b0; seek_drv = 1'b0;
    wait_idle();
    check(cur_cyl == 8'd57, "R3 cylinder kept", int'(cur_cyl), 57);
    sense(8'h04, "R3 seek error bit");

    // reads
    run_xfer(0, 1, 5, 3 * SB, "R4 R11 read to track end exact");
    run_xfer(0, 0, 2, 2, "R5 read short mid sector");
    run_xfer(0, 0, 3, SB, "R6 read ends on sector boundary");
    run_xfer(0, 1, 6, 100, "R5 R11 read cut at track end");

    // writes
    run_xfer(1, 0, 4, SB + 1, "R7 write pad");
    run_xfer(1, 1, 1, 2 * SB, "R7 write exact boundary");

    // initial-load read: head 0 sector 0
    begin
      bit il;
      exp_xfer(0, 0, 0, 2 * SB, "R1 R4 initial load read", il);
      issue(8'h02, 2 * SB);
      wait_idle();
      sense({6'b0, il, 1'b0}, "R8 initial load length");
    end

    // R10 command while busy is ignored
    begin
      bit il;
      exp_xfer(0, 0, 7, SB, "R10 read with ignored command", il);
      issue(8'h7A, SB);
      repeat (3) @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = 8'hFF; @(negedge clk); cmd_valid = 1'b0;
      wait_idle();
      sense({6'b0, il, 1'b0}, "R10 no reject while busy");
    end

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R11 all expected events seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule